// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block holds one access byte for each of five localities of a trusted-platform register interface and decides which one of them, if any, owns the interface. Software writes a command byte tagged with a locality index: it can ask for use, take ownership by force from a lower-numbered owner, give ownership up, or clear the flag that reports a forced takeover. Any locality's access byte can be read at any time through a combinational read port. The block also drives the current owner's number, an ownership-valid flag, and a one-cycle pulse whenever ownership changes.

Arbitration is by priority. A forced takeover succeeds only from a locality numbered above the current owner. When the owner gives up, ownership goes to the highest-numbered locality with a request waiting. Every locality other than a requester can see that some other locality is waiting.

A two-state machine holds the ownership status. In `ST_FREE` no locality owns the interface. In `ST_HELD` the owner register is meaningful. The named transitions are: T_GRANT (`ST_FREE` to `ST_HELD`, on a request or takeover while free); T_SEIZE (`ST_HELD` to `ST_HELD` with a higher-numbered owner); T_HANDOFF (`ST_HELD` to `ST_HELD` when the owner gives up and a request is waiting); and T_RELEASE (`ST_HELD` to `ST_FREE` when the owner gives up and no request is waiting).

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality is active, `active_valid` is 0, `active_loc` is 0, and every in-range access byte reads 0x81.
- R2: The access byte of an in-range locality is laid out as follows. Bit 7 (register valid) and bit 0 (establishment) are always 1. Bits 6 and 3 always read 0. Bit 5 is active, bit 4 is been-seized, bit 2 is pending-request and bit 1 is request-use. A read of a locality index of 5 or more returns 0xFF.
- R3: A write with bit 1 (request use) while no locality is active makes the writer the owner. The new owner shows at `active_loc` with `active_valid` high in the cycle after the write (T_GRANT).
- R4: A request-use write from a locality other than the owner sets that locality's request bit and leaves ownership alone. The pending bit of locality i is 1 exactly when some other locality j, with j not equal to i, holds a request.
- R5: A write with bit 3 (seize) from a locality numbered below the owner changes nothing. Ownership stays, and the writer keeps any request it had.
- R6: A seize write from a locality numbered above the owner makes the writer the owner and clears the writer's request. The previous owner loses its active bit and gains the been-seized bit 4 (T_SEIZE). A seize write while no locality is active grants ownership, as in R3.
- R7: A write with bit 4 set clears that locality's been-seized flag.
- R8: A write with bit 5 from the owner gives up ownership. The highest-numbered requester becomes owner and its request bit clears (T_HANDOFF). If no locality is requesting, no locality stays active (T_RELEASE). A bit-5 write from a locality that does not own the interface withdraws that locality's request.
- R9: When one write carries several command bits, they are handled in this order: clear been-seized, then give up, then seize, then request. A write of zero has no effect, and bits 0, 2, 6 and 7 of a write are ignored.
- R10: A write whose locality index is 5 or more has no effect.
- R11: `loc_changed` is high for exactly the one cycle in which `active_valid` or `active_loc` first shows a changed owner or a changed valid state, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_loc | input | 3 | Locality index of the write |
| wr_data | input | 8 | Command byte |
| rd_loc | input | 3 | Locality index to read |
| rd_data | output | 8 | Access byte of `rd_loc` (combinational) |
| active_valid | output | 1 | Some locality owns the interface |
| active_loc | output | 3 | Owning locality, 0 when none |
| loc_changed | output | 1 | One-cycle pulse on a change of owner or valid state |

## Verification
The assertions assume that `wr_en`, `wr_loc` and `wr_data` are stable and known around each rising edge. They also assume that an out-of-range locality index can appear on either port, so the properties guard it rather than exclude it. The stimulus drives every input at the falling edge and holds it for a full cycle. Random writes deliberately use indices 5 to 7 about a tenth of the time. Command bytes are drawn both as single command bits and as arbitrary bytes, so that mixed-bit and ignored-bit writes reach the ordered handling path.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

    // Bit positions inside an access byte (read and write share them)
    localparam int ACC_EST    = 0;
    localparam int ACC_REQ    = 1;
    localparam int ACC_PEND   = 2;
    localparam int ACC_SEIZE  = 3;
    localparam int ACC_SEIZED = 4;
    localparam int ACC_ACTIVE = 5;
    localparam int ACC_VALID  = 7;

    typedef enum logic [0:0] {
        ST_FREE = 1'b0,
        ST_HELD = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic clr_seized;
        logic relinquish;
        logic seize;
        logic request;
    } acc_cmd_t;

endpackage

// File: rtl/loc_cmd_decode.sv
module loc_cmd_decode
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int IDX_W   = 3
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_loc,
    input  logic [7:0]       wr_data,
    output acc_cmd_t         cmd,
    output logic             cmd_ok
);

    always_comb begin
        cmd.clr_seized = wr_data[ACC_SEIZED];
        cmd.relinquish = wr_data[ACC_ACTIVE];
        cmd.seize      = wr_data[ACC_SEIZE];
        cmd.request    = wr_data[ACC_REQ];
        cmd_ok = wr_en && (int'(wr_loc) < NUM_LOC) && (|cmd);
    end

endmodule

// File: rtl/loc_prio_pick.sv
module loc_prio_pick #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan upward; the last set bit seen is the highest-numbered one
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/loc_access_view.sv
module loc_access_view
    import loc_arb_pkg::*;
#(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic             held,
    input  logic [IDX_W-1:0] owner,
    input  logic [N-1:0]     req,
    input  logic [N-1:0]     seized,
    input  logic [IDX_W-1:0] rd_loc,
    output logic [7:0]       rd_data
);

    logic [7:0] view [N];

    for (genvar g = 0; g < N; g++) begin : g_view
        logic [N-1:0] others;
        always_comb begin
            others    = req;
            others[g] = 1'b0;
            view[g]   = 8'h00;
            view[g][ACC_VALID]  = 1'b1;
            view[g][ACC_EST]    = 1'b1;
            view[g][ACC_ACTIVE] = held && (owner == IDX_W'(g));
            view[g][ACC_SEIZED] = seized[g];
            view[g][ACC_REQ]    = req[g];
            view[g][ACC_PEND]   = |others;
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < N; i++) begin
            if (rd_loc == IDX_W'(i)) rd_data = view[i];
        end
    end

endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_loc,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_loc,
    output logic [7:0]       rd_data,
    output logic             active_valid,
    output logic [IDX_W-1:0] active_loc,
    output logic             loc_changed
);

    arb_state_e         st, ns;
    logic [IDX_W-1:0]   owner, n_owner;
    logic [NUM_LOC-1:0] req, n_req;
    logic [NUM_LOC-1:0] seized, n_seized;
    logic               chg_q;
    acc_cmd_t           cmd;
    logic               cmd_ok;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;

    loc_cmd_decode #(.NUM_LOC(NUM_LOC), .IDX_W(IDX_W)) u_dec (
        .wr_en  (wr_en),
        .wr_loc (wr_loc),
        .wr_data(wr_data),
        .cmd    (cmd),
        .cmd_ok (cmd_ok)
    );

    loc_prio_pick #(.N(NUM_LOC), .IDX_W(IDX_W)) u_pick (
        .vec(req),
        .any(pick_any),
        .idx(pick_idx)
    );

    loc_access_view #(.N(NUM_LOC), .IDX_W(IDX_W)) u_view (
        .held   (st == ST_HELD),
        .owner  (owner),
        .req    (req),
        .seized (seized),
        .rd_loc (rd_loc),
        .rd_data(rd_data)
    );

    // Next-state: command bits applied in fixed order
    always_comb begin
        ns       = st;
        n_owner  = owner;
        n_req    = req;
        n_seized = seized;
        if (cmd_ok) begin
            if (cmd.clr_seized) n_seized[wr_loc] = 1'b0;

            if (cmd.relinquish) begin
                if (ns == ST_HELD && n_owner == wr_loc) begin
                    if (pick_any) begin            // T_HANDOFF
                        n_owner         = pick_idx;
                        n_req[pick_idx] = 1'b0;
                    end else begin                 // T_RELEASE
                        ns      = ST_FREE;
                        n_owner = '0;
                    end
                end else begin
                    n_req[wr_loc] = 1'b0;          // withdraw request
                end
            end

            if (cmd.seize) begin
                unique case (ns)
                    ST_FREE: begin                 // T_GRANT
                        ns            = ST_HELD;
                        n_owner       = wr_loc;
                        n_req[wr_loc] = 1'b0;
                    end
                    ST_HELD: begin
                        if (wr_loc > n_owner) begin  // T_SEIZE
                            n_seized[n_owner] = 1'b1;
                            n_owner           = wr_loc;
                            n_req[wr_loc]     = 1'b0;
                        end
                    end
                endcase
            end

            if (cmd.request) begin
                unique case (ns)
                    ST_FREE: begin                 // T_GRANT
                        ns            = ST_HELD;
                        n_owner       = wr_loc;
                        n_req[wr_loc] = 1'b0;
                    end
                    ST_HELD: begin
                        if (wr_loc != n_owner) n_req[wr_loc] = 1'b1;
                    end
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_FREE;
            owner  <= '0;
            req    <= '0;
            seized <= '0;
            chg_q  <= 1'b0;
        end else begin
            st     <= ns;
            owner  <= n_owner;
            req    <= n_req;
            seized <= n_seized;
            chg_q  <= (ns != st) || (ns == ST_HELD && n_owner != owner);
        end
    end

    // Outputs
    always_comb begin
        active_valid = (st == ST_HELD);
        active_loc   = owner;
        loc_changed  = chg_q;
    end

    // ---------------- assertions ----------------
    a_r1_free_owner_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !active_valid |-> active_loc == '0);

    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_loc) < NUM_LOC |-> rd_data[ACC_VALID] && rd_data[ACC_EST]
                                   && !rd_data[6] && !rd_data[ACC_SEIZE]);

    a_r3_grant_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 8'h02 && int'(wr_loc) < NUM_LOC && !active_valid)
        |=> active_valid && active_loc == $past(wr_loc));

    a_r5_low_seize_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 8'h08 && active_valid && wr_loc < active_loc)
        |=> active_valid && $stable(active_loc) && $stable(req));

    a_r6_high_seize_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 8'h08 && active_valid && wr_loc > active_loc
         && int'(wr_loc) < NUM_LOC)
        |=> active_loc == $past(wr_loc) && seized[$past(active_loc)]);

    a_r8_owner_not_requesting: assert property (@(posedge clk) disable iff (!rst_n)
        active_valid |-> !req[active_loc]);

    a_r9_zero_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 8'h00)
        |=> $stable(req) && $stable(seized) && $stable(active_valid) && $stable(active_loc));

    a_r10_out_of_range_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_loc) >= NUM_LOC)
        |=> $stable(req) && $stable(seized) && $stable(active_valid) && $stable(active_loc));

    a_r11_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        loc_changed |-> ($past(active_valid) != active_valid) || ($past(active_loc) != active_loc));

endmodule

// File: tb/loc_arbiter_bench.sv
`timescale 1ns/100ps
module loc_arbiter_bench;

    localparam int NL = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_loc = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_loc = '0;
    logic [7:0] rd_data;
    logic       active_valid;
    logic [2:0] active_loc;
    logic       loc_changed;

    int vectors = 0;
    int miscompares = 0;

    logic [NL-1:0] m_req = '0;
    logic [NL-1:0] m_seized = '0;
    bit            m_held = 1'b0;
    int            m_owner = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    loc_arbiter u_loc_arbiter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_loc(wr_loc),
        .wr_data(wr_data), .rd_loc(rd_loc), .rd_data(rd_data),
        .active_valid(active_valid), .active_loc(active_loc),
        .loc_changed(loc_changed)
    );

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(int i);
        logic [7:0]    b;
        logic [NL-1:0] oth;
        if (i >= NL) return 8'hFF;
        b = 8'h81;
        b[5] = m_held && (m_owner == i);
        b[4] = m_seized[i];
        b[1] = m_req[i];
        oth = m_req;
        oth[i] = 1'b0;
        b[2] = |oth;
        return b;
    endfunction

    task automatic grant(int w);
        m_held = 1'b1;
        m_owner = w;
        m_req[w] = 1'b0;
    endtask

    // Reference behaviour written from R3..R10
    task automatic model_write(int w, logic [7:0] d);
        int hi;
        if (w >= NL) return;
        if (d[4]) m_seized[w] = 1'b0;
        if (d[5]) begin
            if (m_held && m_owner == w) begin
                hi = -1;
                for (int k = 0; k < NL; k++) if (m_req[k]) hi = k;
                if (hi >= 0) begin
                    m_owner = hi;
                    m_req[hi] = 1'b0;
                end else begin
                    m_held = 1'b0;
                    m_owner = 0;
                end
            end else begin
                m_req[w] = 1'b0;
            end
        end
        if (d[3]) begin
            if (!m_held) grant(w);
            else if (w > m_owner) begin
                m_seized[m_owner] = 1'b1;
                grant(w);
            end
        end
        if (d[1]) begin
            if (!m_held) grant(w);
            else if (w != m_owner) m_req[w] = 1'b1;
        end
    endtask

    task automatic check_all(string tag, bit exp_chg);
        check("R11", "loc_changed", {7'd0, loc_changed}, {7'd0, exp_chg});
        check("R3", "active_valid", {7'd0, active_valid}, {7'd0, m_held});
        check("R3", "active_loc", {5'd0, active_loc}, m_held ? 8'(m_owner) : 8'd0);
        for (int i = 0; i < 8; i++) begin
            rd_loc = 3'(i);
            #0.2;
            check(tag, $sformatf("access byte loc %0d", i), rd_data, exp_byte(i));
        end
    endtask

    task automatic do_write(string tag, int w, logic [7:0] d);
        bit ph;
        int po;
        bit chg;
        @(negedge clk);
        wr_en = 1'b1;
        wr_loc = 3'(w);
        wr_data = d;
        ph = m_held;
        po = m_owner;
        model_write(w, d);
        chg = (ph != m_held) || (m_held && po != m_owner);
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
        check_all(tag, chg);
    endtask

    task automatic idle_pulse_check();
        @(negedge clk);
        check("R11", "loc_changed after idle cycle", {7'd0, loc_changed}, 8'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] cmds [6];
        int seed_dummy;
        seed_dummy = $urandom(32'h1A2B);
        cmds[0] = 8'h02; cmds[1] = 8'h08; cmds[2] = 8'h20;
        cmds[3] = 8'h10; cmds[4] = 8'h22; cmds[5] = 8'h0A;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 1'b0);

        do_write("R10", 6, 8'h02);        // out of range: nothing
        do_write("R3", 0, 8'h02);         // free -> owner 0
        idle_pulse_check();
        do_write("R4", 2, 8'h02);         // 2 waits, pending elsewhere
        do_write("R4", 3, 8'h02);
        do_write("R6", 2, 8'h08);         // 2 takes over from 0
        do_write("R4", 1, 8'h02);
        do_write("R5", 1, 8'h08);         // lower seize ignored
        do_write("R7", 0, 8'h10);         // clear 0's seized flag
        do_write("R6", 4, 8'h08);         // locality 4 accepted
        do_write("R8", 4, 8'h20);         // handoff to 3
        do_write("R8", 1, 8'h20);         // non-owner withdraws
        do_write("R9", 3, 8'h00);         // zero write
        do_write("R9", 0, 8'hC5);         // only ignored bits
        do_write("R9", 0, 8'h02);
        do_write("R9", 3, 8'h22);         // give up, then request again
        do_write("R8", 0, 8'h20);
        do_write("R8", 3, 8'h20);         // release, now free
        do_write("R6", 2, 8'h08);         // seize while free
        do_write("R9", 2, 8'h30);         // clear + release
        idle_pulse_check();

        for (int n = 0; n < 1500; n++) begin
            int w;
            logic [7:0] d;
            w = ($urandom_range(0, 9) == 0) ? $urandom_range(5, 7) : $urandom_range(0, 4);
            if ($urandom_range(0, 3) == 0) d = 8'($urandom);
            else d = cmds[$urandom_range(0, 5)];
            do_write("R9", w, d);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule